// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Function Select

This block is a memory-mapped general-purpose I/O controller for up to 64 pins. Its registers are arranged in groups, and each group holds one 32-bit word per bank of 32 pins. Software drives output latches through separate set and clear words, so it never has to read, modify and write them. It reads pad levels through a two-stage synchronizer. It routes each pin either to its own GPIO latch or to one of three peripheral output and enable pairs, selected by a 2-bit code.

Each pin has a sticky interrupt flag. The flag is raised on any change of the synchronized input, or continuously while the input is high in level mode. Software clears it by writing one to it. An enable mask gates the flags into a read-only identity view and into a single combined interrupt line. The register port is a plain 32-bit write strobe plus address, and the read data is registered.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads 0, every pad output enable and pad output is 0, and the interrupt line is low.
- R2: Writing a word to the set group (byte base 0x00) sets each output latch whose data bit is 1. Latches whose data bit is 0 keep their value.
- R3: Writing a word to the clear group (byte base 0x04) clears each output latch whose data bit is 1. Latches whose data bit is 0 keep their value.
- R4: The output group (0x08) reads back the output latches. The output-enable group (0x10) is read/write. For a pin in GPIO mode, its enable bit drives pad_oe and its latch drives pad_out one cycle after the write.
- R5: With NB = 1 + (NPINS-1)/32 banks, the word of a plain group at byte base G that holds pin p sits at byte G*NB + 4*(p/32), at bit p mod 32. With 64 pins the bank 1 set word is 0x04.
- R6: Function-select bit b of pin p is held at byte 0x20*NB + 4*(b + NB*(p/32)), which with two banks gives 0x40/0x44 for bank 0 and 0x48/0x4C for bank 1. The code is {bit1,bit0}. Code 0 selects GPIO, and code n in 1..3 drives pad_out and pad_oe from periph_out and periph_oe bit (n-1)*NPINS + p.
- R7: The input group (0x0C) returns the pin levels after a two-flop synchronizer, whatever the pin direction.
- R8: With the pin's sense bit at 0 (sense group 0x28), any change of the synchronized input sets the pin's status bit in the status group (0x14). Both rising and falling changes count.
- R9: With the sense bit at 1, the status bit is set on every cycle that the synchronized input is high. This hardware set wins over a clear write in the same cycle, and a falling input does not set the bit.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: The identity group (0x1C) reads status AND enable (enable group 0x18). irq_out is high exactly when some identity bit is set.
- R12: The input and identity groups ignore writes, and addresses that map to no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the address of the previous cycle |
| pin_in | input | NPINS | Asynchronous pad input levels |
| periph_out | input | 3*NPINS | Peripheral output values, function n at slice n-1 |
| periph_oe | input | 3*NPINS | Peripheral output enables, function n at slice n-1 |
| pad_out | output | NPINS | Registered pad output value |
| pad_oe | output | NPINS | Registered pad output enable |
| irq_out | output | 1 | Combined interrupt, OR of all identity bits |

## Verification
The bench aims at the register layout of the second bank and at the interleaved select words. A decoder that spaced banks wrongly would alter a bank 0 pin or the wrong select bit, and pin 40 would then not follow its peripheral. It checks both edge directions and that level sensing survives a clear write. A design that let the clear win, or that flagged only rising edges, would read status 0 where 1 is expected. Random mixes of set, clear, enable and select writes with changing peripheral inputs catch a set or clear that touches zero bits, and a mux that reads the wrong slice.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BANK_W = 32;

  // Register groups, as word index of the byte base (base / 4).
  localparam int G_SET   = 0;
  localparam int G_CLR   = 1;
  localparam int G_OUT   = 2;
  localparam int G_IN    = 3;
  localparam int G_OE    = 4;
  localparam int G_STAT  = 5;
  localparam int G_IEN   = 6;
  localparam int G_IDENT = 7;
  localparam int G_SEL   = 8;
  localparam int G_SENSE = 10;

  typedef enum logic [1:0] {
    FN_GPIO = 2'd0,
    FN_P1   = 2'd1,
    FN_P2   = 2'd2,
    FN_P3   = 2'd3
  } pin_fn_e;

  function automatic int plain_word(input int grp, input int nb, input int bank);
    return grp * nb + bank;
  endfunction

  function automatic int sel_word(input int bitn, input int nb, input int bank);
    return G_SEL * nb + bitn + nb * bank;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;

endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_in,
  input  logic [W-1:0] sense_lvl,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status_q
);

  logic [W-1:0] prev_q;
  logic [W-1:0] hit;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      hit[i] = sense_lvl[i] ? sync_in[i] : (sync_in[i] ^ prev_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= sync_in;
      status_q <= (status_q & ~clr_mask) | hit;
    end
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((($past(status_q) & ~$past(clr_mask))) & ~status_q) == '0)); // R10

  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(sync_in) & $past(sense_lvl)) & ~status_q) == '0)); // R9

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   gpio_out,
  input  logic [NPINS-1:0]   gpio_oe,
  input  logic [NPINS-1:0]   sel0,
  input  logic [NPINS-1:0]   sel1,
  input  logic [3*NPINS-1:0] periph_out,
  input  logic [3*NPINS-1:0] periph_oe,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe
);

  logic [NPINS-1:0] nxt_out;
  logic [NPINS-1:0] nxt_oe;

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      case (pin_fn_e'({sel1[p], sel0[p]}))
        FN_P1: begin
          nxt_out[p] = periph_out[p];
          nxt_oe[p]  = periph_oe[p];
        end
        FN_P2: begin
          nxt_out[p] = periph_out[NPINS + p];
          nxt_oe[p]  = periph_oe[NPINS + p];
        end
        FN_P3: begin
          nxt_out[p] = periph_out[2*NPINS + p];
          nxt_oe[p]  = periph_oe[2*NPINS + p];
        end
        default: begin
          nxt_out[p] = gpio_out[p];
          nxt_oe[p]  = gpio_oe[p];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0)); // R1

  AST_GPIO_PASS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((~($past(sel0) | $past(sel1))) & ($past(gpio_out) ^ pad_out)) == '0)); // R6

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 64,
  parameter int AW    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NPINS-1:0]   pin_in,
  input  logic [3*NPINS-1:0] periph_out,
  input  logic [3*NPINS-1:0] periph_oe,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe,
  output logic               irq_out
);

  localparam int NB   = 1 + (NPINS - 1) / BANK_W;
  localparam int PADW = NB * BANK_W;

  function automatic logic [PADW-1:0] make_mask();
    logic [PADW-1:0] m;
    m = '0;
    for (int i = 0; i < NPINS; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [PADW-1:0] VMASK = make_mask();

  logic [AW-3:0]    widx;
  logic [PADW-1:0]  out_q, oe_q, ien_q, sel0_q, sel1_q, sense_q;
  logic [NPINS-1:0] sync_pins;
  logic [PADW-1:0]  sync_pad;
  logic [PADW-1:0]  status;
  logic [PADW-1:0]  ident;
  logic [PADW-1:0]  clr_mask;
  logic [31:0]      rd_word;
  logic [31:0]      rdata_q;

  assign widx     = reg_addr[AW-1:2];
  assign sync_pad = PADW'(sync_pins);
  assign ident    = status & ien_q;
  assign irq_out  = |ident;

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pin_in),
    .d_sync  (sync_pins)
  );

  always_comb begin
    clr_mask = '0;
    for (int k = 0; k < NB; k++) begin
      if (reg_wr && int'(widx) == plain_word(G_STAT, NB, k))
        clr_mask[k*BANK_W +: BANK_W] = reg_wdata & VMASK[k*BANK_W +: BANK_W];
    end
  end

  gpio_irq_latch #(.W(PADW)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .sync_in   (sync_pad),
    .sense_lvl (sense_q),
    .clr_mask  (clr_mask),
    .status_q  (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      oe_q    <= '0;
      ien_q   <= '0;
      sel0_q  <= '0;
      sel1_q  <= '0;
      sense_q <= '0;
    end else if (reg_wr) begin
      for (int k = 0; k < NB; k++) begin
        if (int'(widx) == plain_word(G_SET, NB, k))
          out_q[k*BANK_W +: BANK_W] <= out_q[k*BANK_W +: BANK_W]
                                       | (reg_wdata & VMASK[k*BANK_W +: BANK_W]);
        if (int'(widx) == plain_word(G_CLR, NB, k))
          out_q[k*BANK_W +: BANK_W] <= out_q[k*BANK_W +: BANK_W]
                                       & ~(reg_wdata & VMASK[k*BANK_W +: BANK_W]);
        if (int'(widx) == plain_word(G_OE, NB, k))
          oe_q[k*BANK_W +: BANK_W] <= reg_wdata & VMASK[k*BANK_W +: BANK_W];
        if (int'(widx) == plain_word(G_IEN, NB, k))
          ien_q[k*BANK_W +: BANK_W] <= reg_wdata & VMASK[k*BANK_W +: BANK_W];
        if (int'(widx) == plain_word(G_SENSE, NB, k))
          sense_q[k*BANK_W +: BANK_W] <= reg_wdata & VMASK[k*BANK_W +: BANK_W];
        if (int'(widx) == sel_word(0, NB, k))
          sel0_q[k*BANK_W +: BANK_W] <= reg_wdata & VMASK[k*BANK_W +: BANK_W];
        if (int'(widx) == sel_word(1, NB, k))
          sel1_q[k*BANK_W +: BANK_W] <= reg_wdata & VMASK[k*BANK_W +: BANK_W];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NB; k++) begin
      if (int'(widx) == plain_word(G_OUT, NB, k))   rd_word = out_q[k*BANK_W +: BANK_W];
      if (int'(widx) == plain_word(G_IN, NB, k))    rd_word = sync_pad[k*BANK_W +: BANK_W];
      if (int'(widx) == plain_word(G_OE, NB, k))    rd_word = oe_q[k*BANK_W +: BANK_W];
      if (int'(widx) == plain_word(G_STAT, NB, k))  rd_word = status[k*BANK_W +: BANK_W];
      if (int'(widx) == plain_word(G_IEN, NB, k))   rd_word = ien_q[k*BANK_W +: BANK_W];
      if (int'(widx) == plain_word(G_IDENT, NB, k)) rd_word = ident[k*BANK_W +: BANK_W];
      if (int'(widx) == plain_word(G_SENSE, NB, k)) rd_word = sense_q[k*BANK_W +: BANK_W];
      if (int'(widx) == sel_word(0, NB, k))         rd_word = sel0_q[k*BANK_W +: BANK_W];
      if (int'(widx) == sel_word(1, NB, k))         rd_word = sel1_q[k*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_word;
  end

  assign reg_rdata = rdata_q;

  gpio_pad_mux #(.NPINS(NPINS)) u_mux (
    .clk        (clk),
    .rst        (rst),
    .gpio_out   (out_q[NPINS-1:0]),
    .gpio_oe    (oe_q[NPINS-1:0]),
    .sel0       (sel0_q[NPINS-1:0]),
    .sel1       (sel1_q[NPINS-1:0]),
    .periph_out (periph_out),
    .periph_oe  (periph_oe),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
  );

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && int'(widx) == plain_word(G_SET, NB, 0)) |=>
      ((out_q[BANK_W-1:0] & $past(reg_wdata & VMASK[BANK_W-1:0])) == $past(reg_wdata & VMASK[BANK_W-1:0]))); // R2

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && int'(widx) == plain_word(G_CLR, NB, 0)) |=>
      ((out_q[BANK_W-1:0] & $past(reg_wdata & VMASK[BANK_W-1:0])) == '0)); // R3

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (ien_q != '0)); // R11

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb_top;

  localparam int NPINS = 64;
  localparam int AW    = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               reg_wr = 1'b0;
  logic [AW-1:0]      reg_addr = '0;
  logic [31:0]        reg_wdata = '0;
  logic [31:0]        reg_rdata;
  logic [NPINS-1:0]   pin_in = '0;
  logic [3*NPINS-1:0] periph_out = '0;
  logic [3*NPINS-1:0] periph_oe = '0;
  logic [NPINS-1:0]   pad_out;
  logic [NPINS-1:0]   pad_oe;
  logic               irq_out;

  int n_chk = 0;
  int n_err = 0;

  logic [63:0] m_out, m_oe, m_s0, m_s1;

  always #5 clk = ~clk;

  gpio_bank_ctrl #(.NPINS(NPINS), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  // Byte addresses per the layout requirements (two banks).
  function automatic logic [7:0] a_plain(input int base, input int bank);
    return 8'(base * 2 + 4 * bank);
  endfunction
  function automatic logic [7:0] a_sel(input int bitn, input int bank);
    return 8'(8'h40 + 4 * (bitn + 2 * bank));
  endfunction

  function automatic logic [63:0] exp_pad(input logic use_oe);
    logic [63:0] r;
    for (int p = 0; p < 64; p++) begin
      case ({m_s1[p], m_s0[p]})
        2'd0: r[p] = use_oe ? m_oe[p] : m_out[p];
        2'd1: r[p] = use_oe ? periph_oe[p] : periph_out[p];
        2'd2: r[p] = use_oe ? periph_oe[64+p] : periph_out[64+p];
        default: r[p] = use_oe ? periph_oe[128+p] : periph_out[128+p];
      endcase
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic rand_periph();
    for (int i = 0; i < 6; i++) begin
      periph_out[i*32 +: 32] = $urandom;
      periph_oe[i*32 +: 32]  = $urandom;
    end
  endtask

  task automatic apply(input int op, input int bank, input logic [31:0] d);
    case (op)
      0: begin wr(a_plain(8'h00, bank), d); m_out[bank*32 +: 32] = m_out[bank*32 +: 32] | d; end
      1: begin wr(a_plain(8'h04, bank), d); m_out[bank*32 +: 32] = m_out[bank*32 +: 32] & ~d; end
      2: begin wr(a_plain(8'h10, bank), d); m_oe[bank*32 +: 32] = d; end
      3: begin wr(a_sel(0, bank), d); m_s0[bank*32 +: 32] = d; end
      default: begin wr(a_sel(1, bank), d); m_s1[bank*32 +: 32] = d; end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    m_out = '0; m_oe = '0; m_s0 = '0; m_s1 = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, 64'h0);
    check("R1 pad_out", pad_out, 64'h0);
    check("R1 irq_out", {63'h0, irq_out}, 64'h0);
    rd(a_plain(8'h08, 1), r); check("R1 out bank1", {32'h0, r}, 64'h0);
    rd(a_plain(8'h10, 0), r); check("R1 oe bank0", {32'h0, r}, 64'h0);
    rd(a_sel(1, 1), r);       check("R1 sel1 bank1", {32'h0, r}, 64'h0);

    // R2 R3 R5: bank 1 set word at 0x04, clear at 0x0C, out at 0x14
    wr(8'h04, 32'h0000_0101);
    rd(8'h14, r); check("R2 R5 set bank1", {32'h0, r}, 64'h0000_0101);
    rd(8'h10, r); check("R5 bank0 untouched", {32'h0, r}, 64'h0);
    wr(8'h04, 32'h0000_8000);
    rd(8'h14, r); check("R2 zero bits keep", {32'h0, r}, 64'h0000_8101);
    wr(8'h0C, 32'h0000_0001);
    rd(8'h14, r); check("R3 clear bank1", {32'h0, r}, 64'h0000_8100);
    m_out = 64'h0000_8100_0000_0000;

    // R4 output enable drives pads for GPIO pins
    wr(8'h24, 32'h0000_0100); m_oe = 64'h0000_0100_0000_0000;
    @(negedge clk);
    check("R4 pad_oe pin40", pad_oe, 64'h0000_0100_0000_0000);
    check("R4 pad_out", pad_out, 64'h0000_8100_0000_0000);
    rd(8'h24, r); check("R4 oe readback", {32'h0, r}, 64'h0000_0100);

    // R6 interleaved select words: pin 40 code 3, pin 2 code 2
    for (int i = 0; i < 6; i++) begin periph_out[i*32 +: 32] = 32'h0; periph_oe[i*32 +: 32] = 32'h0; end
    periph_out[128 + 40] = 1'b1; periph_oe[128 + 40] = 1'b1;
    periph_out[64 + 2]   = 1'b1;
    wr(8'h48, 32'h0000_0100); m_s0[40] = 1'b1;
    wr(8'h4C, 32'h0000_0100); m_s1[40] = 1'b1;
    wr(8'h44, 32'h0000_0004); m_s1[2] = 1'b1;
    @(negedge clk);
    check("R6 pad_out alt", pad_out, exp_pad(1'b0));
    check("R6 pad_oe alt", pad_oe, exp_pad(1'b1));
    check("R6 pin40 follows fn3", {63'h0, pad_out[40]}, 64'h1);
    rd(8'h40, r); check("R6 bank0 sel0 empty", {32'h0, r}, 64'h0);

    // R2 R3 R4 R6 random mix
    for (int it = 0; it < 300; it++) begin
      rand_periph();
      apply(int'($urandom % 5), int'($urandom % 2), $urandom);
      @(negedge clk);
      check("R2 R3 R6 rand pad_out", pad_out, exp_pad(1'b0));
      check("R4 R6 rand pad_oe", pad_oe, exp_pad(1'b1));
      if (it % 25 == 0) begin
        rd(8'h10, r); check("R2 R3 rand out0", {32'h0, r}, {32'h0, m_out[31:0]});
        rd(8'h14, r); check("R2 R3 rand out1", {32'h0, r}, {32'h0, m_out[63:32]});
      end
    end

    // R7 input readback independent of direction
    wr(8'h20, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 64'hA5C3_0F12_3C96_E187;
    settle();
    rd(8'h18, r); check("R7 in bank0", {32'h0, r}, 64'h3C96_E187);
    rd(8'h1C, r); check("R7 in bank1", {32'h0, r}, 64'hA5C3_0F12);

    // R10 clear all status
    @(negedge clk); pin_in = '0;
    settle();
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h28, r); check("R10 cleared bank0", {32'h0, r}, 64'h0);

    // R8 rising change
    @(negedge clk); pin_in[3] = 1'b1;
    settle();
    rd(8'h28, r); check("R8 rise sets", {32'h0, r}, 64'h8);
    rd(8'h38, r); check("R11 ident masked", {32'h0, r}, 64'h0);
    check("R11 irq low masked", {63'h0, irq_out}, 64'h0);
    wr(8'h30, 32'h0000_0008);
    check("R11 irq high", {63'h0, irq_out}, 64'h1);
    rd(8'h38, r); check("R11 ident", {32'h0, r}, 64'h8);
    wr(8'h28, 32'h0000_0000);
    rd(8'h28, r); check("R10 zero write keeps", {32'h0, r}, 64'h8);
    wr(8'h28, 32'h0000_0008);
    rd(8'h28, r); check("R10 w1c", {32'h0, r}, 64'h0);
    check("R11 irq drops", {63'h0, irq_out}, 64'h0);

    // R8 falling change
    @(negedge clk); pin_in[3] = 1'b0;
    settle();
    rd(8'h28, r); check("R8 fall sets", {32'h0, r}, 64'h8);
    wr(8'h28, 32'h0000_0008);

    // R9 level mode: set wins over clear, no set on fall
    wr(8'h50, 32'h0000_0008);
    @(negedge clk); pin_in[3] = 1'b1;
    settle();
    wr(8'h28, 32'h0000_0008);
    rd(8'h28, r); check("R9 level beats clear", {32'h0, r}, 64'h8);
    @(negedge clk); pin_in[3] = 1'b0;
    settle();
    wr(8'h28, 32'h0000_0008);
    settle();
    rd(8'h28, r); check("R9 no set on fall", {32'h0, r}, 64'h0);

    // R12 read-only groups and unmapped addresses
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, r); check("R12 input ignores write", {32'h0, r}, 64'h0);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, r); check("R12 ident ignores write", {32'h0, r}, 64'h0);
    rd(8'h58, r); check("R12 unmapped 0x58", {32'h0, r}, 64'h0);
    rd(8'hFC, r); check("R12 unmapped 0xFC", {32'h0, r}, 64'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule